// File: doc/BRIEF.md
# Confidence-Tagged Conditional Branch Direction Predictor

This block predicts whether a conditional branch is taken and also reports how far that prediction can be trusted. Its direction state is a table of 2048 two-bit saturating counters. The table is indexed by hashing the branch PC with a global history of recent outcomes. A second table of the same depth stores, for each entry, a run-length counter of correct predictions in a row. A misprediction sets that counter back to zero. At lookup the counter is compared against a programmable threshold. A lookup marked as belonging to the primary path is flagged as low-confidence when the run is shorter than the threshold. The front end uses that flag to choose the branches worth following down both directions.

A lookup presents a PC and receives the predicted direction, the low-confidence flag and the history value it used. Two clock edges later, these appear on registered outputs. When the branch resolves, the resolve port carries the PC, that saved history, the real outcome and whether the prediction was wrong. Both counters of the entry are then updated. A mispredicted resolve also rewrites the global history to the corrected path. After reset, the block sweeps both tables to their initial values. During that sweep it drops all requests and holds `ready` low.

Top module: `conf_bpred`

## Requirements
- R1: After reset, `ready` stays low for exactly 2048 cycles while every entry is written with direction counter 1 (weakly not-taken) and run counter 0. Lookups and resolves presented while `ready` is low produce no result and change no state. Once high, `ready` stays high.
- R2: A lookup accepted with `lk_valid` in cycle t raises `pr_valid` for one cycle, with its results, after the second rising edge following t.
- R3: The entry index is bits [12:2] of the PC XOR the 11-bit global history. `pr_hist` returns the history value that the lookup used.
- R4: `pr_taken` is bit 1 of the entry's 2-bit direction counter. A resolve moves that counter up by one when taken and down by one when not taken, and it saturates at 0 and 3.
- R5: A resolve with `rs_mispred` low increments the entry's 4-bit run counter, which stays at 15 instead of wrapping.
- R6: A resolve with `rs_mispred` high clears the entry's run counter to 0.
- R7: `pr_lowconf` is 1 exactly when the lookup had `lk_primary` high and the entry's run counter was below the `lk_thresh` value sampled with the lookup. Otherwise it is 0.
- R8: When a prediction is delivered, the global history shifts left by one and takes the predicted direction in bit 0.
- R9: A resolve with `rs_mispred` high sets the global history to `{rs_hist[9:0], rs_taken}` on the next edge.
- R10: Resolves to the same entry in consecutive cycles compound: the second update starts from the counters the first one wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Byte address of the branch to predict |
| lk_primary | input | 1 | Lookup comes from the primary path |
| lk_thresh | input | 4 | Run length below which a branch is low-confidence |
| rs_valid | input | 1 | Resolve request |
| rs_pc | input | 32 | Byte address of the resolving branch |
| rs_hist | input | 11 | History returned with that branch's prediction |
| rs_taken | input | 1 | Actual outcome |
| rs_mispred | input | 1 | Prediction was wrong |
| ready | output | 1 | Table initialisation finished |
| pr_valid | output | 1 | Prediction result valid |
| pr_taken | output | 1 | Predicted direction |
| pr_lowconf | output | 1 | Low-confidence flag |
| pr_hist | output | 11 | History used for this prediction |

## Verification
A run counter that wraps, misses a clear, or loses a back-to-back update shows as a wrong `pr_lowconf` on the next lookup of that entry, two cycles after the lookup is issued. A direction counter that is off shows as a wrong `pr_taken` at the same point. A corrupted or unrepaired global history does more damage. Every later lookup lands on the wrong entry, and the `pr_hist` of the very next result already exposes it. The tests therefore re-read each entry right after driving it to a saturation point, a clear or a run of updates. They also step the history through shifts and repairs, so that each fault surfaces within one lookup.

// File: rtl/conf_bpred_pkg.sv
package conf_bpred_pkg;

  typedef enum logic [1:0] {
    DIR_SNT = 2'd0,
    DIR_WNT = 2'd1,
    DIR_WT  = 2'd2,
    DIR_ST  = 2'd3
  } dir_ctr_e;

  function automatic logic [1:0] dir_step(input logic [1:0] cur, input logic taken);
    if (taken) begin
      return (cur == DIR_ST) ? cur : cur + 2'd1;
    end
    return (cur == DIR_SNT) ? cur : cur - 2'd1;
  endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table #(
  parameter int AW = 11,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first synchronous reads, one synchronous write
  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int HW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          shift_bit,
  input  logic          repair_en,
  input  logic [HW-1:0] repair_hist,
  input  logic          repair_bit,
  output logic [HW-1:0] ghr
);
  logic unused_hist_msb;
  assign unused_hist_msb = repair_hist[HW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ghr <= '0;
    end else if (repair_en) begin
      ghr <= {repair_hist[HW-2:0], repair_bit};
    end else if (shift_en) begin
      ghr <= {ghr[HW-2:0], shift_bit};
    end
  end

  assert_ghr_repair_R9: assert property (@(posedge clk) disable iff (rst)
    repair_en |=> (ghr == {$past(repair_hist[HW-2:0]), $past(repair_bit)}));

  assert_ghr_shift_R8: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !repair_en) |=> (ghr == {$past(ghr[HW-2:0]), $past(shift_bit)}));
endmodule

// File: rtl/bp_update.sv
module bp_update
  import conf_bpred_pkg::*;
#(
  parameter int AW = 11,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rs_fire,
  input  logic [AW-1:0] rs_idx,
  input  logic          rs_taken,
  input  logic          rs_mispred,
  input  logic [1:0]    dir_rdata,
  input  logic [CW-1:0] conf_rdata,
  output logic          ready,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [1:0]    dir_wdata,
  output logic [CW-1:0] conf_wdata
);
  localparam int            DEPTH    = 1 << AW;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CONF_MAX = '1;

  logic          busy;
  logic [AW-1:0] init_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      init_cnt <= '0;
    end else if (busy) begin
      init_cnt <= init_cnt + AW'(1);
      if (init_cnt == LAST_IDX) busy <= 1'b0;
    end
  end

  assign ready = !busy;

  // stage 1: table read data arrives here
  logic          s1_valid;
  logic [AW-1:0] s1_idx;
  logic          s1_taken;
  logic          s1_mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_taken <= 1'b0;
      s1_mis   <= 1'b0;
    end else begin
      s1_valid <= rs_fire;
      s1_idx   <= rs_idx;
      s1_taken <= rs_taken;
      s1_mis   <= rs_mispred;
    end
  end

  // one-deep bypass of the write issued on the previous edge
  logic          byp_valid;
  logic [AW-1:0] byp_addr;
  logic [1:0]    byp_dir;
  logic [CW-1:0] byp_conf;
  logic          byp_hit;
  logic [1:0]    cur_dir;
  logic [CW-1:0] cur_conf;
  logic [1:0]    new_dir;
  logic [CW-1:0] new_conf;

  always_comb begin
    byp_hit  = byp_valid && (byp_addr == s1_idx);
    cur_dir  = byp_hit ? byp_dir  : dir_rdata;
    cur_conf = byp_hit ? byp_conf : conf_rdata;
    new_dir  = dir_step(cur_dir, s1_taken);
    if (s1_mis)                    new_conf = '0;
    else if (cur_conf == CONF_MAX) new_conf = CONF_MAX;
    else                           new_conf = cur_conf + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_valid <= 1'b0;
      byp_addr  <= '0;
      byp_dir   <= '0;
      byp_conf  <= '0;
    end else begin
      byp_valid <= s1_valid && !busy;
      byp_addr  <= s1_idx;
      byp_dir   <= new_dir;
      byp_conf  <= new_conf;
    end
  end

  always_comb begin
    if (busy) begin
      we         = 1'b1;
      waddr      = init_cnt;
      dir_wdata  = DIR_WNT;
      conf_wdata = '0;
    end else begin
      we         = s1_valid;
      waddr      = s1_idx;
      dir_wdata  = new_dir;
      conf_wdata = new_conf;
    end
  end

  assert_ready_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  assert_conf_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_mis && !busy) |-> (conf_wdata >= cur_conf));

  assert_conf_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mis && !busy) |=> (byp_conf == '0));
endmodule

// File: rtl/conf_bpred.sv
module conf_bpred #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 11,
  parameter int CNF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_primary,
  input  logic [CNF_W-1:0] lk_thresh,
  input  logic             rs_valid,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic [IDX_W-1:0] rs_hist,
  input  logic             rs_taken,
  input  logic             rs_mispred,
  output logic             ready,
  output logic             pr_valid,
  output logic             pr_taken,
  output logic             pr_lowconf,
  output logic [IDX_W-1:0] pr_hist
);
  localparam int PC_LO = 2;
  localparam int PC_HI = IDX_W + PC_LO - 1;

  logic             lk_fire;
  logic             rs_fire;
  logic [IDX_W-1:0] ghr;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] rs_idx;

  assign lk_fire = lk_valid && ready;
  assign rs_fire = rs_valid && ready;
  assign lk_idx  = lk_pc[PC_HI:PC_LO] ^ ghr;
  assign rs_idx  = rs_pc[PC_HI:PC_LO] ^ rs_hist;

  logic [1:0]       dir_a, dir_b, dir_w;
  logic [CNF_W-1:0] cnf_a, cnf_b, cnf_w;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_waddr;

  bp_table #(.AW(IDX_W), .DW(2)) u_dir_tbl (
    .clk(clk), .ra_addr(lk_idx), .ra_data(dir_a),
    .rb_addr(rs_idx), .rb_data(dir_b),
    .we(tbl_we), .waddr(tbl_waddr), .wdata(dir_w)
  );

  bp_table #(.AW(IDX_W), .DW(CNF_W)) u_cnf_tbl (
    .clk(clk), .ra_addr(lk_idx), .ra_data(cnf_a),
    .rb_addr(rs_idx), .rb_data(cnf_b),
    .we(tbl_we), .waddr(tbl_waddr), .wdata(cnf_w)
  );

  bp_update #(.AW(IDX_W), .CW(CNF_W)) u_update (
    .clk(clk), .rst(rst), .rs_fire(rs_fire), .rs_idx(rs_idx),
    .rs_taken(rs_taken), .rs_mispred(rs_mispred),
    .dir_rdata(dir_b), .conf_rdata(cnf_b), .ready(ready),
    .we(tbl_we), .waddr(tbl_waddr), .dir_wdata(dir_w), .conf_wdata(cnf_w)
  );

  // lookup stage 1 (table read in flight)
  logic             s1_valid;
  logic             s1_primary;
  logic [CNF_W-1:0] s1_thresh;
  logic [IDX_W-1:0] s1_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_primary <= 1'b0;
      s1_thresh  <= '0;
      s1_hist    <= '0;
    end else begin
      s1_valid   <= lk_fire;
      s1_primary <= lk_primary;
      s1_thresh  <= lk_thresh;
      s1_hist    <= ghr;
    end
  end

  // lookup stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid   <= 1'b0;
      pr_taken   <= 1'b0;
      pr_lowconf <= 1'b0;
      pr_hist    <= '0;
    end else begin
      pr_valid <= s1_valid;
      if (s1_valid) begin
        pr_taken   <= dir_a[1];
        pr_lowconf <= s1_primary && (cnf_a < s1_thresh);
        pr_hist    <= s1_hist;
      end
    end
  end

  bp_hist #(.HW(IDX_W)) u_hist (
    .clk(clk), .rst(rst),
    .shift_en(s1_valid), .shift_bit(dir_a[1]),
    .repair_en(rs_fire && rs_mispred), .repair_hist(rs_hist), .repair_bit(rs_taken),
    .ghr(ghr)
  );

  logic unused_bits;
  assign unused_bits = ^{lk_pc[PC_W-1:PC_HI+1], lk_pc[PC_LO-1:0],
                         rs_pc[PC_W-1:PC_HI+1], rs_pc[PC_LO-1:0], dir_a[0]};

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    pr_valid |-> $past(lk_valid && ready, 2));

  assert_lowconf_primary_R7: assert property (@(posedge clk) disable iff (rst)
    pr_lowconf |-> $past(lk_primary, 2));
endmodule

// File: tb/conf_bpred_bench.sv
`timescale 1ns/1ps
module conf_bpred_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_primary = 1'b0;
  logic [3:0]  lk_thresh = '0;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic [10:0] rs_hist = '0;
  logic        rs_taken = 1'b0;
  logic        rs_mispred = 1'b0;
  logic        ready, pr_valid, pr_taken, pr_lowconf;
  logic [10:0] pr_hist;

  always #2 clk = ~clk;

  conf_bpred u_conf_bpred (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_primary(lk_primary),
    .lk_thresh(lk_thresh), .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_hist(rs_hist),
    .rs_taken(rs_taken), .rs_mispred(rs_mispred), .ready(ready), .pr_valid(pr_valid),
    .pr_taken(pr_taken), .pr_lowconf(pr_lowconf), .pr_hist(pr_hist)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        taken;
    logic        low;
    logic [10:0] hist;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [1:0]  dir_m  [2048];
  logic [3:0]  conf_m [2048];
  logic [10:0] ghr_m = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as the design delivers them
  always @(negedge clk) begin
    if (!rst && pr_valid) begin
      if (q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R2: actual unexpected result expected none");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " taken R4"},  32'(pr_taken),   32'(e.taken));
        chk({e.tag, " lowconf R7"}, 32'(pr_lowconf), 32'(e.low));
        chk({e.tag, " hist R3"},   32'(pr_hist),    32'(e.hist));
      end
    end
  end

  task automatic lookup(input logic [31:0] pc, input logic prim, input logic [3:0] thr,
                        input string tag);
    exp_t e;
    logic [10:0] idx;
    idx     = pc[12:2] ^ ghr_m;
    e.taken = dir_m[idx][1];
    e.low   = prim && (conf_m[idx] < thr);
    e.hist  = ghr_m;
    e.tag   = tag;
    q.push_back(e);
    ghr_m = {ghr_m[9:0], e.taken};  // R8
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_primary = prim; lk_thresh = thr;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R2 no result after one edge", 32'(pr_valid), 32'd0);
    @(negedge clk);
    chk("R2 result after two edges", 32'(pr_valid), 32'd1);
    @(negedge clk);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [10:0] h, input logic tk,
                         input logic mis, input bit gap);
    logic [10:0] idx;
    idx = pc[12:2] ^ h;
    if (tk) dir_m[idx] = (dir_m[idx] == 2'd3) ? 2'd3 : dir_m[idx] + 2'd1;
    else    dir_m[idx] = (dir_m[idx] == 2'd0) ? 2'd0 : dir_m[idx] - 2'd1;
    if (mis) conf_m[idx] = '0;
    else     conf_m[idx] = (conf_m[idx] == 4'hf) ? 4'hf : conf_m[idx] + 4'd1;
    if (mis) ghr_m = {h[9:0], tk};
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_hist = h; rs_taken = tk; rs_mispred = mis;
    if (gap) begin
      @(negedge clk);
      rs_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  localparam logic [31:0] PC_A = 32'h0000_1000;
  localparam logic [31:0] PC_B = 32'h0000_2000;

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 2048; i++) begin
      dir_m[i]  = 2'd1;
      conf_m[i] = 4'd0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 pr_valid in reset state", 32'(pr_valid), 32'd0);
    chk("R1 ready low during init",   32'(ready),    32'd0);

    // request during init must be dropped
    lk_valid = 1'b1; lk_pc = PC_A; lk_primary = 1'b1; lk_thresh = 4'd3;
    rs_valid = 1'b1; rs_pc = PC_A; rs_hist = 11'h7ff; rs_taken = 1'b1; rs_mispred = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0;
    n = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      n++;
      chk("R1 no result while not ready", 32'(pr_valid), 32'd0);
    end
    while (!ready && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R1 init length", 32'(n), 32'd2048);

    // fresh entry, primary and non-primary
    lookup(PC_A, 1'b1, 4'd3, "fresh primary R1");
    lookup(PC_A, 1'b0, 4'd3, "fresh non-primary R7");

    // three correct taken resolves: dir saturates at 3, run = 3
    for (int k = 0; k < 3; k++) resolve(PC_A, 11'd0, 1'b1, 1'b0, 1'b1);
    lookup(PC_A, 1'b1, 4'd3, "run equals threshold R5");
    // history now 1: different entry, checks shift R8 and hash R3
    lookup(PC_A, 1'b1, 4'd4, "shifted history R8");

    // mispredict: clears run R6, dir 3->2 still taken R4, repairs history R9
    resolve(PC_A, 11'd0, 1'b0, 1'b1, 1'b1);
    lookup(PC_A, 1'b1, 4'd1, "after mispredict R6 R9");

    // twenty correct resolves saturate the run counter
    for (int k = 0; k < 20; k++) resolve(PC_A, 11'd0, 1'b1, 1'b0, 1'b1);
    resolve(PC_B, 11'd0, 1'b0, 1'b1, 1'b1);   // history back to 0
    lookup(PC_A, 1'b1, 4'd15, "run saturates R5");

    // back-to-back resolves to one entry compound
    resolve(PC_A, 11'd0, 1'b1, 1'b1, 1'b1);   // run cleared, history = 1
    resolve(PC_A, 11'd0, 1'b1, 1'b0, 1'b0);
    resolve(PC_A, 11'd0, 1'b1, 1'b0, 1'b1);
    resolve(PC_B, 11'd0, 1'b0, 1'b1, 1'b1);   // history back to 0
    lookup(PC_A, 1'b1, 4'd2, "back-to-back run R10");
    resolve(PC_B, 11'd0, 1'b0, 1'b1, 1'b1);
    lookup(PC_A, 1'b1, 4'd3, "back-to-back below threshold R10");

    // repair with a wide history value, then non-zero hash
    resolve(PC_B, 11'h2a5, 1'b1, 1'b1, 1'b1);
    lookup(PC_B, 1'b1, 4'd1, "repaired history R9");

    repeat (4) @(negedge clk);
    chk("R2 all results delivered", 32'(q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule